// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one channel of a memory-to-memory or memory/peripheral DMA engine that runs a list of transfer descriptors kept in memory. Software places the address of the first descriptor in the channel's next-descriptor register and sets the run bit. The channel then works through the list on its own. For each descriptor it reads four words, moves the programmed number of bytes from the source address to the target address, and then follows the link to the next descriptor. It stops when a link word carries the stop flag.

The channel reaches memory through a simple single-outstanding request/acknowledge master port. Software reaches it through a register port with combinational read data. A level interrupt output reports the start, end, bus-error and stopped conditions. A single peripheral request input paces transfers that are under flow control, one burst per request. A no-fetch mode runs a single transfer taken straight from the source, target and command registers.

Top module: `dchain_dma_channel`

## Requirements
- R1: After reset the control/status word reads 0x00000008: run is clear, stop-state (bit 3) is set, and all status flags are zero. The interrupt output is low.
- R2: A descriptor is fetched as four word reads at pointer +0, +4, +8 and +12, in that order. The words are the link, source, target and command. The next descriptor is fetched from link bits 31:4 with the low four bits zero, and the link register reads back the last fetched link word.
- R3: Data moves in units selected by command bits 15:14 (1 = 1 byte, 2 = 2 bytes, 3 or 0 = 4 bytes). A tail shorter than the unit moves as single bytes. Each unit is read from the source and then written to the target with mem_size 0/1/2 for 1/2/4 bytes, little-endian in the low data lanes. The source address advances by the unit size when command bit 31 is set; the target address advances the same way when bit 30 is set.
- R4: When a descriptor whose link word has bit 0 set completes, the channel clears run and reads stop-state 1.
- R5: Loading a descriptor whose command bit 22 is set sets the start flag (bit 1). Completing a descriptor whose command bit 21 is set sets the end flag (bit 2).
- R6: Writing 1 to bits 2, 1 or 0 of the control/status word clears that flag. Reading the word and writing the same value back clears every flag that was pending.
- R7: The interrupt is high whenever any of the start, end or bus-error flags is set, or when the stop-interrupt enable (bit 29) is set while the channel is stopped.
- R8: A descriptor with length zero completes with no data read or write.
- R9: When command bit 29 or bit 28 selects flow control, each burst waits for the request input to be high. The burst is 8, 16 or 32 bytes for command bits 17:16 equal to 1, 2 or 3, and 8 bytes for 0. Control/status bit 8 reads the request input, delayed by one cycle.
- R10: With command bit 18 set, the bytes within each 2- or 4-byte unit are written in reversed order.
- R11: With control bit 30 set, starting the channel moves data using the source, target and command registers as written, with no descriptor reads, and stops afterwards.
- R12: A memory error response sets the bus-error flag (bit 0), clears run and stops the channel.
- R13: Clearing run halts the channel after the current unit completes. The command register length field (bits 12:0) then shows the bytes not yet moved, and the source and target registers show the next addresses.
- R14: With channel index CHAN, control/status sits at byte 4·CHAN. The link, source, target and command registers sit at 0x200 + 16·CHAN + 0, 4, 8 and 0xC. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_size | output | 2 | Access size: 0 = byte, 1 = halfword, 2 = word |
| mem_wdata | output | 32 | Memory write data, low lanes |
| mem_ack | input | 1 | Memory access completed |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_err | input | 1 | Error response, valid with mem_ack |
| dreq | input | 1 | Peripheral request for flow-controlled bursts |
| irq | output | 1 | Channel interrupt |

## Verification
The hardest states to reach from the ports are a flow-controlled transfer parked between bursts and a run-bit clear that lands in the middle of a descriptor. The bench gets there by holding the request input low after the descriptor has loaded and then pulsing it for exactly one clock edge, so exactly one 8-byte burst moves. It then clears run and reads the length, source and target registers to see the partial progress. A reference model in the bench builds the expected sequence of memory writes from each descriptor and the source contents, and compares every acknowledged write against it.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 13;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECIDE,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } eng_state_e;

  // command word fields
  localparam int C_INC_SRC  = 31;
  localparam int C_INC_TGT  = 30;
  localparam int C_FLOW_SRC = 29;
  localparam int C_FLOW_TGT = 28;
  localparam int C_START_IE = 22;
  localparam int C_END_IE   = 21;
  localparam int C_SWAP     = 18;
endpackage

// File: rtl/dchain_unit.sv
module dchain_unit
  import dchain_pkg::*;
(
  input  logic [LEN_W-1:0]  len,
  input  logic [1:0]        width_code,
  input  logic [1:0]        burst_code,
  input  logic              swap,
  input  logic [WORD_W-1:0] rd_word,
  output logic [2:0]        unit_bytes,
  output logic [1:0]        unit_size,
  output logic [5:0]        burst_bytes,
  output logic [WORD_W-1:0] wr_word
);
  logic [2:0] width_bytes;

  always_comb begin
    case (width_code)
      2'd1:    width_bytes = 3'd1;
      2'd2:    width_bytes = 3'd2;
      default: width_bytes = 3'd4;
    endcase
    unit_bytes = (len >= LEN_W'(width_bytes)) ? width_bytes : 3'd1;
    case (unit_bytes)
      3'd1:    unit_size = 2'd0;
      3'd2:    unit_size = 2'd1;
      default: unit_size = 2'd2;
    endcase
    case (burst_code)
      2'd2:    burst_bytes = 6'd16;
      2'd3:    burst_bytes = 6'd32;
      default: burst_bytes = 6'd8;
    endcase
  end

  always_comb begin
    case (unit_bytes)
      3'd1:    wr_word = {24'd0, rd_word[7:0]};
      3'd2:    wr_word = swap ? {16'd0, rd_word[7:0], rd_word[15:8]}
                              : {16'd0, rd_word[15:0]};
      default: wr_word = swap ? {rd_word[7:0], rd_word[15:8], rd_word[23:16], rd_word[31:24]}
                              : rd_word;
    endcase
  end
endmodule

// File: rtl/dchain_csr.sv
module dchain_csr (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_run,
  input  logic        wr_nofetch,
  input  logic        wr_stop_ie,
  input  logic [2:0]  wr_clr,
  input  logic        set_start,
  input  logic        set_end,
  input  logic        set_berr,
  input  logic        hw_stop,
  input  logic        eng_idle,
  input  logic        dreq,
  output logic        run,
  output logic        nofetch,
  output logic [31:0] ctrl_word,
  output logic        irq
);
  logic       run_q, run_d;
  logic       nofetch_q, nofetch_d;
  logic       stop_ie_q, stop_ie_d;
  logic [2:0] flag_q, flag_d;   // {end, start, bus error}
  logic       req_q;
  logic       stopped;

  always_comb begin
    run_d     = run_q;
    nofetch_d = nofetch_q;
    stop_ie_d = stop_ie_q;
    flag_d    = flag_q;
    if (wr_en) begin
      run_d     = wr_run;
      nofetch_d = wr_nofetch;
      stop_ie_d = wr_stop_ie;
      flag_d    = flag_q & ~wr_clr;
    end
    if (hw_stop) run_d = 1'b0;
    flag_d = flag_d | {set_end, set_start, set_berr};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      nofetch_q <= 1'b0;
      stop_ie_q <= 1'b0;
      flag_q    <= 3'd0;
      req_q     <= 1'b0;
    end else begin
      run_q     <= run_d;
      nofetch_q <= nofetch_d;
      stop_ie_q <= stop_ie_d;
      flag_q    <= flag_d;
      req_q     <= dreq;
    end
  end

  assign stopped   = eng_idle & ~run_q;
  assign run       = run_q;
  assign nofetch   = nofetch_q;
  assign ctrl_word = {run_q, nofetch_q, stop_ie_q, 20'd0, req_q, 4'd0, stopped, flag_q};
  assign irq       = (|flag_q) | (stop_ie_q & stopped);

  // R4
  stop_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stop |=> !run_q);
  // R12
  berr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_berr |=> (flag_q[0] && !run_q));
  // R5
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[1]) |-> $past(set_start));
endmodule

// File: rtl/dchain_engine.sv
module dchain_engine
  import dchain_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              nofetch,
  input  logic              dreq,
  input  logic              sw_we,
  input  logic [1:0]        sw_sel,
  input  logic [WORD_W-1:0] sw_wdata,
  input  logic [2:0]        unit_bytes,
  input  logic [1:0]        unit_size,
  input  logic [5:0]        burst_bytes,
  input  logic [WORD_W-1:0] unit_word,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_err,
  output logic [WORD_W-1:0] nxt_q,
  output logic [WORD_W-1:0] src_q,
  output logic [WORD_W-1:0] tgt_q,
  output logic [WORD_W-1:0] cmd_q,
  output logic              set_start,
  output logic              set_end,
  output logic              set_berr,
  output logic              hw_stop,
  output logic              idle
);
  eng_state_e        st_q, st_d;
  logic [1:0]        idx_q, idx_d;
  logic [WORD_W-1:0] fptr_q, fptr_d;
  logic [WORD_W-1:0] nxt_d, src_d, tgt_d, cmd_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic [5:0]        burst_q, burst_d;
  logic [LEN_W-1:0]  len;
  logic              flow;

  assign len  = cmd_q[LEN_W-1:0];
  assign flow = cmd_q[C_FLOW_SRC] | cmd_q[C_FLOW_TGT];

  always_comb begin
    st_d = st_q; idx_d = idx_q; fptr_d = fptr_q;
    nxt_d = nxt_q; src_d = src_q; tgt_d = tgt_q; cmd_d = cmd_q;
    data_d = data_q; burst_d = burst_q;
    set_start = 1'b0; set_end = 1'b0; set_berr = 1'b0; hw_stop = 1'b0;

    if (sw_we) begin
      case (sw_sel)
        2'd0:    nxt_d = sw_wdata;
        2'd1:    src_d = sw_wdata;
        2'd2:    tgt_d = sw_wdata;
        default: cmd_d = sw_wdata;
      endcase
    end

    case (st_q)
      ST_IDLE: begin
        if (run) begin
          burst_d = 6'd0;
          if (nofetch) st_d = ST_DECIDE;
          else begin
            fptr_d = {nxt_q[WORD_W-1:4], 4'd0};
            idx_d  = 2'd0;
            st_d   = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        if (mem_ack) begin
          if (mem_err) begin
            set_berr = 1'b1; hw_stop = 1'b1; st_d = ST_IDLE;
          end else begin
            case (idx_q)
              2'd0:    nxt_d = mem_rdata;
              2'd1:    src_d = mem_rdata;
              2'd2:    tgt_d = mem_rdata;
              default: begin
                cmd_d     = mem_rdata;
                set_start = mem_rdata[C_START_IE];
                burst_d   = 6'd0;
                st_d      = ST_DECIDE;
              end
            endcase
            idx_d = idx_q + 2'd1;
            if (!run) st_d = ST_IDLE;
          end
        end
      end
      ST_DECIDE: begin
        if (!run) st_d = ST_IDLE;
        else if (len == '0) st_d = ST_DONE;
        else if (flow && burst_q == 6'd0) begin
          if (dreq) begin
            burst_d = burst_bytes;
            st_d    = ST_READ;
          end
        end else st_d = ST_READ;
      end
      ST_READ: begin
        if (mem_ack) begin
          if (mem_err) begin
            set_berr = 1'b1; hw_stop = 1'b1; st_d = ST_IDLE;
          end else begin
            data_d = unit_word;
            st_d   = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        if (mem_ack) begin
          if (mem_err) begin
            set_berr = 1'b1; hw_stop = 1'b1; st_d = ST_IDLE;
          end else begin
            if (cmd_q[C_INC_SRC]) src_d = src_q + WORD_W'(unit_bytes);
            if (cmd_q[C_INC_TGT]) tgt_d = tgt_q + WORD_W'(unit_bytes);
            cmd_d[LEN_W-1:0] = len - LEN_W'(unit_bytes);
            burst_d = (burst_q > 6'(unit_bytes)) ? burst_q - 6'(unit_bytes) : 6'd0;
            st_d    = ST_DECIDE;
          end
        end
      end
      ST_DONE: begin
        set_end = cmd_q[C_END_IE];
        if (!run) st_d = ST_IDLE;
        else if (nofetch || nxt_q[0]) begin
          hw_stop = 1'b1;
          st_d    = ST_IDLE;
        end else begin
          fptr_d = {nxt_q[WORD_W-1:4], 4'd0};
          idx_d  = 2'd0;
          st_d   = ST_FETCH;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; idx_q <= 2'd0; fptr_q <= '0;
      nxt_q <= '0; src_q <= '0; tgt_q <= '0; cmd_q <= '0;
      data_q <= '0; burst_q <= 6'd0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; fptr_q <= fptr_d;
      nxt_q <= nxt_d; src_q <= src_d; tgt_q <= tgt_d; cmd_q <= cmd_d;
      data_q <= data_d; burst_q <= burst_d;
    end
  end

  always_comb begin
    mem_req   = (st_q == ST_FETCH) || (st_q == ST_READ) || (st_q == ST_WRITE);
    mem_we    = (st_q == ST_WRITE);
    mem_wdata = data_q;
    case (st_q)
      ST_FETCH: begin mem_addr = fptr_q + {28'd0, idx_q, 2'b00}; mem_size = 2'd2; end
      ST_READ:  begin mem_addr = src_q; mem_size = unit_size; end
      default:  begin mem_addr = tgt_q; mem_size = unit_size; end
    endcase
  end

  assign idle = (st_q == ST_IDLE);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R8
  nonzero_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && st_q != ST_FETCH) |-> (len != '0));
  // R3
  size_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && st_q != ST_FETCH) |-> (LEN_W'(unit_bytes) <= len));
endmodule

// File: rtl/dchain_dma_channel.sv
module dchain_dma_channel
  import dchain_pkg::*;
#(
  parameter int CHAN = 0,
  parameter int AW   = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [1:0]    mem_size,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_err,
  input  logic          dreq,
  output logic          irq
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(CHAN * 4);
  localparam logic [AW-5:0] DESC_TAG  = (AW-4)'((32'h200 + CHAN * 16) >> 4);

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic        ctrl_hit, desc_hit;
  logic        run, nofetch;
  logic [31:0] ctrl_word, nxt_q, src_q, tgt_q, cmd_q, unit_word;
  logic [2:0]  unit_bytes;
  logic [1:0]  unit_size;
  logic [5:0]  burst_bytes;
  logic        set_start, set_end, set_berr, hw_stop, eng_idle;

  assign ctrl_hit = (reg_addr == CTRL_ADDR);
  assign desc_hit = (reg_addr[AW-1:4] == DESC_TAG) && (reg_addr[1:0] == 2'b00);

  dchain_unit u_unit (
    .len(cmd_q[LEN_W-1:0]), .width_code(cmd_q[15:14]), .burst_code(cmd_q[17:16]),
    .swap(cmd_q[C_SWAP]), .rd_word(mem_rdata),
    .unit_bytes(unit_bytes), .unit_size(unit_size), .burst_bytes(burst_bytes),
    .wr_word(unit_word)
  );

  dchain_csr u_csr (
    .clk(clk), .rst_n(rst_i_n),
    .wr_en(reg_we && ctrl_hit), .wr_run(reg_wdata[31]), .wr_nofetch(reg_wdata[30]),
    .wr_stop_ie(reg_wdata[29]), .wr_clr(reg_wdata[2:0]),
    .set_start(set_start), .set_end(set_end), .set_berr(set_berr), .hw_stop(hw_stop),
    .eng_idle(eng_idle), .dreq(dreq),
    .run(run), .nofetch(nofetch), .ctrl_word(ctrl_word), .irq(irq)
  );

  dchain_engine u_engine (
    .clk(clk), .rst_n(rst_i_n), .run(run), .nofetch(nofetch), .dreq(dreq),
    .sw_we(reg_we && desc_hit), .sw_sel(reg_addr[3:2]), .sw_wdata(reg_wdata),
    .unit_bytes(unit_bytes), .unit_size(unit_size), .burst_bytes(burst_bytes),
    .unit_word(unit_word),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .nxt_q(nxt_q), .src_q(src_q), .tgt_q(tgt_q), .cmd_q(cmd_q),
    .set_start(set_start), .set_end(set_end), .set_berr(set_berr), .hw_stop(hw_stop),
    .idle(eng_idle)
  );

  always_comb begin
    reg_rdata = 32'd0;
    if (ctrl_hit) reg_rdata = ctrl_word;
    else if (desc_hit) begin
      case (reg_addr[3:2])
        2'd0:    reg_rdata = nxt_q;
        2'd1:    reg_rdata = src_q;
        2'd2:    reg_rdata = tgt_q;
        default: reg_rdata = cmd_q;
      endcase
    end
  end
endmodule

// File: tb/test_dchain_dma_channel.sv
module test_dchain_dma_channel;
  localparam int AW = 12;
  localparam logic [31:0] ERR_BASE = 32'hE000_0000;
  localparam logic [31:0] INC2 = 32'hC000_0000;
  localparam logic [31:0] W1 = 32'h4000, W2 = 32'h8000, W4 = 32'hC000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0] mem_size;
  logic mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic dreq = 1'b0;
  logic irq;

  always #4 clk = ~clk;

  dchain_dma_channel #(.CHAN(0), .AW(AW)) i_dchain_dma_channel (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .dreq(dreq), .irq(irq)
  );

  int n_checks = 0, n_err = 0, n_rd = 0, n_wr = 0;
  logic [7:0]  mem [logic [31:0]];
  logic [31:0] exp_addr[$], exp_data[$];
  logic [1:0]  exp_size[$];
  logic [31:0] rd_log[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rbyte(logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 8'h00;
  endfunction

  task automatic put_word(logic [31:0] a, logic [31:0] w);
    for (int b = 0; b < 4; b++) mem[a + b] = w[8*b +: 8];
  endtask

  // Reference model: expected write sequence of one descriptor
  task automatic plan(logic [31:0] src, logic [31:0] tgt, logic [31:0] cmd);
    int len = int'(cmd[12:0]);
    int wb = (cmd[15:14] == 2'd1) ? 1 : (cmd[15:14] == 2'd2) ? 2 : 4;
    logic [31:0] s = src, t = tgt;
    while (len > 0) begin
      int u = (len >= wb) ? wb : 1;
      logic [31:0] d = '0;
      for (int b = 0; b < u; b++) begin
        if (cmd[18]) d[8*(u-1-b) +: 8] = rbyte(s + b);
        else         d[8*b +: 8]       = rbyte(s + b);
      end
      exp_addr.push_back(t);
      exp_data.push_back(d);
      exp_size.push_back(u == 1 ? 2'd0 : u == 2 ? 2'd1 : 2'd2);
      if (cmd[31]) s += u;
      if (cmd[30]) t += u;
      len -= u;
    end
  endtask

  // memory responder, compares every accepted write with the model
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        int nb = 1 << mem_size;
        mem_ack = 1'b1;
        mem_err = (mem_addr >= ERR_BASE);
        if (mem_we) begin
          n_wr++;
          if (exp_addr.size() == 0) chk("R3 unexpected write addr", mem_addr, 32'hFFFF_FFFF);
          else begin
            chk("R3 write addr", mem_addr, exp_addr.pop_front());
            chk("R3/R10 write data", mem_wdata, exp_data.pop_front());
            chk("R3 write size", 32'(mem_size), 32'(exp_size.pop_front()));
          end
          if (!mem_err) for (int b = 0; b < nb; b++) mem[mem_addr + b] = mem_wdata[8*b +: 8];
        end else begin
          n_rd++;
          rd_log.push_back(mem_addr);
          mem_rdata = '0;
          for (int b = 0; b < nb; b++) mem_rdata[8*b +: 8] = rbyte(mem_addr + b);
        end
      end else begin
        mem_ack = 1'b0;
        mem_err = 1'b0;
      end
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_stopped();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd(12'h000, v);
      if (v[3]) break;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int r0, w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(12'h000, v); chk("R1 ctrl after reset", v, 32'h8);
    chk("R1 irq after reset", 32'(irq), 0);
    rd(12'h204, v); chk("R1 source reg after reset", v, 0);

    // R14 unmapped address and register readback
    wr(12'h208, 32'h1234_5670);
    rd(12'h208, v); chk("R14 target reg readback", v, 32'h1234_5670);
    rd(12'h004, v); chk("R14 unmapped reads zero", v, 0);

    // two-descriptor chain: R2 R4 R5 R6 R7
    for (int i = 0; i < 24; i++) mem[32'h1000 + i] = 8'(8'h30 + i);
    put_word(32'h100, 32'h140); put_word(32'h104, 32'h1000); put_word(32'h108, 32'h2000);
    put_word(32'h10C, INC2 | 32'h0040_0000 | W4 | 32'd8);
    put_word(32'h140, 32'h1);   put_word(32'h144, 32'h1008); put_word(32'h148, 32'h2010);
    put_word(32'h14C, INC2 | 32'h0020_0000 | W4 | 32'd12);
    plan(32'h1000, 32'h2000, INC2 | W4 | 32'd8);
    plan(32'h1008, 32'h2010, INC2 | W4 | 32'd12);
    rd_log.delete(); r0 = n_rd;
    wr(12'h200, 32'h100);
    wr(12'h000, 32'h8000_0000);
    wait_stopped();
    chk("R2 fetch word0 addr", rd_log[0], 32'h100);
    chk("R2 fetch word1 addr", rd_log[1], 32'h104);
    chk("R2 fetch word3 addr", rd_log[3], 32'h10C);
    chk("R2 second descriptor fetch addr", rd_log[6], 32'h140);
    chk("R2 total reads", 32'(n_rd - r0), 13);
    chk("R3 chain writes all seen", 32'(exp_addr.size()), 0);
    rd(12'h000, v); chk("R4/R5 ctrl after chain", v, 32'hE);
    chk("R7 irq with flags", 32'(irq), 1);
    rd(12'h200, v); chk("R2 link readback", v, 32'h1);
    rd(12'h000, v); wr(12'h000, v);
    rd(12'h000, v); chk("R6 read-write-back clears flags", v, 32'h8);
    chk("R6 irq cleared", 32'(irq), 0);

    // halfword units with byte swap and odd tail: R10 R3
    for (int i = 0; i < 5; i++) mem[32'h1100 + i] = 8'(8'h11 * (i + 1));
    put_word(32'h180, 32'h1); put_word(32'h184, 32'h1100); put_word(32'h188, 32'h2100);
    put_word(32'h18C, INC2 | 32'h0004_0000 | W2 | 32'd5);
    plan(32'h1100, 32'h2100, INC2 | 32'h0004_0000 | W2 | 32'd5);
    wr(12'h200, 32'h180); wr(12'h000, 32'h8000_0000);
    wait_stopped();
    chk("R10 swapped writes all seen", 32'(exp_addr.size()), 0);

    // fixed target, byte units: R3
    for (int i = 0; i < 3; i++) mem[32'h1200 + i] = 8'(8'hA0 + i);
    put_word(32'h1C0, 32'h1); put_word(32'h1C4, 32'h1200); put_word(32'h1C8, 32'h2200);
    put_word(32'h1CC, 32'h8000_0000 | W1 | 32'd3);
    plan(32'h1200, 32'h2200, 32'h8000_0000 | W1 | 32'd3);
    wr(12'h200, 32'h1C0); wr(12'h000, 32'h8000_0000);
    wait_stopped();
    chk("R3 fixed target writes all seen", 32'(exp_addr.size()), 0);

    // zero length: R8
    put_word(32'h300, 32'h1); put_word(32'h304, ERR_BASE); put_word(32'h308, ERR_BASE);
    put_word(32'h30C, 32'h0020_0000 | W4);
    r0 = n_rd; w0 = n_wr;
    wr(12'h200, 32'h300); wr(12'h000, 32'h8000_0000);
    wait_stopped();
    chk("R8 only fetch reads", 32'(n_rd - r0), 4);
    chk("R8 no writes", 32'(n_wr - w0), 0);
    rd(12'h000, v); chk("R8 end flag, no bus error", v, 32'hC);
    wr(12'h000, 32'h7);

    // flow control with a single request pulse: R9
    for (int i = 0; i < 16; i++) mem[32'h1300 + i] = 8'(8'h60 + i);
    put_word(32'h340, 32'h1); put_word(32'h344, 32'h1300); put_word(32'h348, 32'h2300);
    put_word(32'h34C, INC2 | 32'h2000_0000 | 32'h0001_0000 | W4 | 32'd16);
    plan(32'h1300, 32'h2300, INC2 | W4 | 32'd16);
    r0 = n_rd; w0 = n_wr;
    wr(12'h200, 32'h340); wr(12'h000, 32'h8000_0000);
    repeat (40) @(negedge clk);
    chk("R9 no data read without request", 32'(n_rd - r0), 4);
    dreq = 1'b1; @(negedge clk); dreq = 1'b0;
    repeat (40) @(negedge clk);
    chk("R9 one burst of two words per request", 32'(n_wr - w0), 2);
    dreq = 1'b1;
    wait_stopped();
    rd(12'h000, v); chk("R9 request pending bit", v, 32'h108);
    dreq = 1'b0;
    chk("R9 flow writes all seen", 32'(exp_addr.size()), 0);

    // no-fetch mode: R11
    for (int i = 0; i < 8; i++) mem[32'h1400 + i] = 8'(8'h90 + i);
    wr(12'h204, 32'h1400); wr(12'h208, 32'h2400);
    wr(12'h20C, INC2 | 32'h0020_0000 | W4 | 32'd8);
    plan(32'h1400, 32'h2400, INC2 | W4 | 32'd8);
    r0 = n_rd;
    wr(12'h000, 32'hC000_0000);
    wait_stopped();
    chk("R11 no descriptor reads", 32'(n_rd - r0), 2);
    chk("R11 writes all seen", 32'(exp_addr.size()), 0);
    rd(12'h000, v); chk("R11 ctrl after no-fetch run", v, 32'h4000_000C);
    wr(12'h000, 32'h4);

    // bus error: R12
    put_word(32'h380, 32'h1C0); put_word(32'h384, ERR_BASE); put_word(32'h388, 32'h2500);
    put_word(32'h38C, INC2 | W4 | 32'd4);
    w0 = n_wr;
    wr(12'h200, 32'h380); wr(12'h000, 32'h8000_0000);
    wait_stopped();
    rd(12'h000, v); chk("R12 bus error stops channel", v, 32'h9);
    chk("R12 no write after error", 32'(n_wr - w0), 0);
    chk("R7 bus error interrupts", 32'(irq), 1);
    wr(12'h000, 32'h1);

    // clear run mid-descriptor: R13
    for (int i = 0; i < 8; i++) mem[32'h1600 + i] = 8'(8'hC0 + i);
    put_word(32'h3C0, 32'h1); put_word(32'h3C4, 32'h1600); put_word(32'h3C8, 32'h2600);
    put_word(32'h3CC, INC2 | 32'h1000_0000 | 32'h0001_0000 | W4 | 32'd64);
    plan(32'h1600, 32'h2600, INC2 | W4 | 32'd8);
    wr(12'h200, 32'h3C0); wr(12'h000, 32'h8000_0000);
    repeat (30) @(negedge clk);
    dreq = 1'b1; @(negedge clk); dreq = 1'b0;
    repeat (30) @(negedge clk);
    wr(12'h000, 32'h0);
    wait_stopped();
    rd(12'h20C, v); chk("R13 remaining length", 32'(v[12:0]), 56);
    rd(12'h204, v); chk("R13 source progress", v, 32'h1608);
    rd(12'h208, v); chk("R13 target progress", v, 32'h2608);
    chk("R13 partial writes all seen", 32'(exp_addr.size()), 0);

    // stop interrupt enable: R7
    wr(12'h000, 32'h2000_0000);
    rd(12'h000, v); chk("R7 stop ie readback", v, 32'h2000_0008);
    chk("R7 stop interrupt", 32'(irq), 1);
    wr(12'h000, 32'h0);
    chk("R7 irq low without enable", 32'(irq), 0);

    finish_run();
  end
endmodule